// File: doc/BRIEF.md
# LIN Responder Frame Sequencer

This block follows the phases of a LIN frame on the responder side of a node. It sits behind a byte UART that hands over each received byte with a break indication and a framing-error indication. The phases are break, sync, identifier, data and checksum. The block stores up to eight data bytes, keeps the running checksum, checks the identifier parity and works out the data length from the identifier.

When the node publishes the frame, the block loads the transmit data at the identifier. It sends the bytes one at a time, compares every byte read back from the bus with the byte just sent, and sends the checksum last. While the bus is asleep, the block watches for a wake-up byte.

Status and error flags are visible at the ports. The error flags are sticky until reset. A one-cycle event pulse tells the host that the frame state has moved.

Top module: `lin_frame_seq`

## Requirements
- R1: After reset, `status_o`, `error_o`, `event_o`, `tx_valid_o` and `sync_arm_o` are all zero.
- R2: A received byte flagged as a break, while the bus is awake, has priority over a UART framing error. It sets `status_o` to 0x01 (bit0 = break seen), pulses `sync_arm_o` and pulses `event_o`.
- R3: `sync_done_i` sets status bit1 (synced) only while the break flag is set, the synced flag is clear and no identifier has been taken. Otherwise it has no effect.
- R4: A non-break byte with `rx_ferr_i` high sets error bit5 and clears `status_o` to 0.
- R5: A byte that arrives before both status bit0 and bit1 are set sets error bit4 (protocol) and clears `status_o`.
- R6: The identifier byte must carry bit6 = id0^id1^id2^id4 and bit7 = ~(id1^id3^id4^id5). On a mismatch, error bit0 is set and `status_o` is cleared. Otherwise status bit2 is set, `frame_id_o` takes bits 5:0, and `frame_len_o` becomes 2, 2, 4 or 8 for id bits 5:4 = 00, 01, 10, 11.
- R7: Data bytes are stored at a countdown index that starts at length-1 and ends at lane 0. Lane k sits at `rx_buf_o[8k+7:8k]`. Status bit3 (receiving) is set on data when the node is not transmitting. Status bit5 (all data) is set when the byte for lane 0 is stored.
- R8: The checksum adds the data bytes with an 8-bit add and adds any carry back in. If the checksum byte plus the sum (mod 256) equals 0xFF, `status_o` becomes 0x67. Otherwise error bit2 is set and `status_o` is cleared.
- R9: A byte that arrives after the frame is complete (status bit6) sets error bit3 and clears `status_o`.
- R10: If `publish_i` is high at a valid identifier, the block sets status bit4, loads `pub_data_i` and transmits lane length-1. After each readback equal to the last byte sent, it transmits the next lower lane, or the inverted sum after lane 0. A readback mismatch sets error bit1 and clears `status_o`.
- R11: `sleep_i` sets `status_o` to 0x80. While status bit7 is set, a byte of 0x00 or 0x80 sets error bit6 and clears `status_o`. Any other byte changes no flag and raises no event.
- R12: `event_o` pulses for one cycle on a break, on any change of `status_o`, and when an error bit newly rises. Error bits stay set until reset.
- R13: Every output responds on the first clock edge after the input that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_data_i | input | 8 | Received byte |
| rx_break_i | input | 1 | Byte was a break |
| rx_ferr_i | input | 1 | Byte had a UART framing error |
| sync_done_i | input | 1 | Sync-field measurement finished |
| sleep_i | input | 1 | Put the bus into sleep state |
| publish_i | input | 1 | Node publishes the current frame |
| pub_data_i | input | 64 | Transmit data, lane k at bits 8k+7:8k |
| tx_valid_o | output | 1 | Transmit byte strobe |
| tx_data_o | output | 8 | Byte to transmit |
| sync_arm_o | output | 1 | Start sync-field measurement |
| event_o | output | 1 | Frame state changed |
| status_o | output | 8 | Status flags (break, sync, id, rx, tx, data, frame, sleep) |
| error_o | output | 7 | Error flags (parity, readback, checksum, frame, protocol, UART, wake) |
| frame_id_o | output | 6 | Accepted identifier |
| frame_len_o | output | 4 | Data length in bytes |
| rx_buf_o | output | 64 | Data buffer |

## Verification
Every result of this block comes from one register stage. Status, errors, the event pulse, the sync arm and the transmit byte are all due exactly one clock edge after the cycle in which the input strobe is held. The driver changes inputs on the falling edge and records the expected item with a due cycle one edge later. The monitor compares that item on the following falling edge. Because of this, a missing event pulse or a transmit byte that arrives one cycle early or late counts as a mismatch. The buffer, length and identifier are checked directly once the stimulus has settled.

// File: rtl/lin_seq_pkg.sv
package lin_seq_pkg;

    typedef struct packed {
        logic sleep;
        logic frdy;
        logic drdy;
        logic txd;
        logic rxd;
        logic idr;
        logic sync;
        logic brk;
    } lin_stat_t;

    typedef struct packed {
        logic wake;
        logic ufe;
        logic proto;
        logic frm;
        logic csum;
        logic rdbk;
        logic par;
    } lin_err_t;

    typedef struct packed {
        lin_stat_t  st;
        lin_err_t   err;
        logic [5:0] id;
        logic [3:0] len;
        logic [7:0] sum;
        logic [7:0] last;
        logic       txv;
        logic [7:0] txb;
        logic       arm;
        logic       ev;
    } seq_t;

    localparam logic [7:0] FRAME_OK = 8'h67;

endpackage

// File: rtl/lin_csum_add.sv
module lin_csum_add #(
    parameter int W = 8
) (
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] sum_o
);
    logic [W:0] raw;

    always_comb begin
        raw   = {1'b0, acc_i} + {1'b0, data_i};
        sum_o = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
    end
endmodule

// File: rtl/lin_id_check.sv
module lin_id_check (
    input  logic [7:0] id_byte_i,
    output logic       ok_o,
    output logic [3:0] len_o
);
    logic p0, p1;

    always_comb begin
        p0 = id_byte_i[0] ^ id_byte_i[1] ^ id_byte_i[2] ^ id_byte_i[4];
        p1 = ~(id_byte_i[1] ^ id_byte_i[3] ^ id_byte_i[4] ^ id_byte_i[5]);
        ok_o = (id_byte_i[6] == p0) && (id_byte_i[7] == p1);
        unique case (id_byte_i[5:4])
            2'b10:   len_o = 4'd4;
            2'b11:   len_o = 4'd8;
            default: len_o = 4'd2;
        endcase
    end
endmodule

// File: rtl/lin_frame_seq.sv
module lin_frame_seq
    import lin_seq_pkg::*;
#(
    parameter int NBYTES = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rx_valid_i,
    input  logic [7:0]            rx_data_i,
    input  logic                  rx_break_i,
    input  logic                  rx_ferr_i,
    input  logic                  sync_done_i,
    input  logic                  sleep_i,
    input  logic                  publish_i,
    input  logic [8*NBYTES-1:0]   pub_data_i,
    output logic                  tx_valid_o,
    output logic [7:0]            tx_data_o,
    output logic                  sync_arm_o,
    output logic                  event_o,
    output logic [7:0]            status_o,
    output logic [6:0]            error_o,
    output logic [5:0]            frame_id_o,
    output logic [3:0]            frame_len_o,
    output logic [8*NBYTES-1:0]   rx_buf_o
);
    localparam int LW = (NBYTES > 1) ? $clog2(NBYTES) : 1;

    seq_t                   q, n;
    logic [NBYTES-1:0][7:0] buf_q, buf_d;
    logic [LW-1:0]          left_q, left_d;
    logic [LW-1:0]          first_idx, next_idx;
    logic [7:0]             sum_add;
    logic                   id_ok;
    logic [3:0]             id_len;
    logic                   brk_ev;

    lin_csum_add #(.W(8)) i_csum (
        .acc_i  (q.sum),
        .data_i (rx_data_i),
        .sum_o  (sum_add)
    );

    lin_id_check i_idchk (
        .id_byte_i (rx_data_i),
        .ok_o      (id_ok),
        .len_o     (id_len)
    );

    always_comb begin
        first_idx = LW'(id_len - 4'd1);
        next_idx  = LW'(left_q - 1'b1);
    end

    always_comb begin
        n      = q;
        buf_d  = buf_q;
        left_d = left_q;
        n.txv  = 1'b0;
        n.arm  = 1'b0;
        brk_ev = 1'b0;
        if (rx_valid_i) begin
            if (q.st.sleep) begin
                if (rx_data_i[6:0] == 7'd0) begin
                    n.err.wake = 1'b1;
                    n.st       = '0;
                end
            end else if (rx_break_i) begin
                n.st     = '0;
                n.st.brk = 1'b1;
                n.arm    = 1'b1;
                brk_ev   = 1'b1;
            end else if (rx_ferr_i) begin
                n.err.ufe = 1'b1;
                n.st      = '0;
            end else if (!q.st.brk || !q.st.sync) begin
                n.err.proto = 1'b1;
                n.st        = '0;
            end else if (!q.st.idr) begin
                if (!id_ok) begin
                    n.err.par = 1'b1;
                    n.st      = '0;
                end else begin
                    n.st.idr = 1'b1;
                    n.id     = rx_data_i[5:0];
                    n.len    = id_len;
                    n.sum    = '0;
                    left_d   = first_idx;
                    if (publish_i) begin
                        buf_d    = pub_data_i;
                        n.st.txd = 1'b1;
                        n.txv    = 1'b1;
                        n.txb    = pub_data_i[8*first_idx +: 8];
                        n.last   = pub_data_i[8*first_idx +: 8];
                    end else begin
                        buf_d = '0;
                    end
                end
            end else if (!q.st.drdy) begin
                if (!q.st.txd) n.st.rxd = 1'b1;
                buf_d[left_q] = rx_data_i;
                n.sum         = sum_add;
                left_d        = next_idx;
                if (left_q == '0) n.st.drdy = 1'b1;
                if (q.st.txd) begin
                    if (rx_data_i != q.last) begin
                        n.err.rdbk = 1'b1;
                        n.st       = '0;
                    end else if (left_q == '0) begin
                        n.txv  = 1'b1;
                        n.txb  = ~sum_add;
                        n.last = ~sum_add;
                    end else begin
                        n.txv  = 1'b1;
                        n.txb  = buf_q[next_idx];
                        n.last = buf_q[next_idx];
                    end
                end
            end else if (!q.st.frdy) begin
                if (q.st.txd && (rx_data_i != q.last)) begin
                    n.err.rdbk = 1'b1;
                    n.st       = '0;
                end else if (8'(rx_data_i + q.sum) == 8'hFF) begin
                    n.st = lin_stat_t'(FRAME_OK);
                end else begin
                    n.err.csum = 1'b1;
                    n.st       = '0;
                end
            end else begin
                n.err.frm = 1'b1;
                n.st      = '0;
            end
        end else if (sleep_i) begin
            n.st       = '0;
            n.st.sleep = 1'b1;
        end else if (sync_done_i && q.st.brk && !q.st.sync && !q.st.idr) begin
            n.st.sync = 1'b1;
        end
        n.ev = brk_ev || (n.st != q.st) || (|(n.err & ~q.err));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            buf_q  <= '0;
            left_q <= '0;
        end else begin
            q      <= n;
            buf_q  <= buf_d;
            left_q <= left_d;
        end
    end

    assign tx_valid_o  = q.txv;
    assign tx_data_o   = q.txb;
    assign sync_arm_o  = q.arm;
    assign event_o     = q.ev;
    assign status_o    = q.st;
    assign error_o     = q.err;
    assign frame_id_o  = q.id;
    assign frame_len_o = q.len;

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign rx_buf_o[8*g +: 8] = buf_q[g];
    end

    a_r2_break_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_i && !status_o[7] && rx_break_i) |=> (status_o == 8'h01 && sync_arm_o && event_o));

    a_r4_uart_ferr: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_i && !status_o[7] && !rx_break_i && rx_ferr_i) |=> (error_o[5] && status_o == 8'h00));

    a_r7_rx_tx_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(status_o[3] && status_o[4]));

    a_r8_frame_implies_data: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[6] |-> status_o[5]);

    a_r10_tx_when_publishing: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o |-> status_o[4]);

    a_r11_sleep_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_i && status_o[7] && rx_data_i[6:0] != 7'd0) |=>
        ($stable(status_o) && $stable(error_o) && !event_o));

    a_r12_event_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o != $past(status_o)) |-> event_o);

    a_r12_errors_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ((error_o & $past(error_o)) == $past(error_o)));

endmodule

// File: tb/test_lin_frame_seq.sv
`timescale 1ns/1ps
module test_lin_frame_seq;

    typedef struct {
        int         due;
        logic [7:0] st;
        logic [6:0] err;
        logic       ev;
        logic       txv;
        logic [7:0] txb;
        logic       arm;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid_i = 1'b0;
    logic [7:0]  rx_data_i = '0;
    logic        rx_break_i = 1'b0;
    logic        rx_ferr_i = 1'b0;
    logic        sync_done_i = 1'b0;
    logic        sleep_i = 1'b0;
    logic        publish_i = 1'b0;
    logic [63:0] pub_data_i = '0;
    logic        tx_valid_o, sync_arm_o, event_o;
    logic [7:0]  tx_data_o, status_o;
    logic [6:0]  error_o;
    logic [5:0]  frame_id_o;
    logic [3:0]  frame_len_o;
    logic [63:0] rx_buf_o;

    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;
    exp_t sb[$];

    lin_frame_seq i_lin_frame_seq (
        .clk(clk), .rst_n(rst_n), .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i),
        .rx_break_i(rx_break_i), .rx_ferr_i(rx_ferr_i), .sync_done_i(sync_done_i),
        .sleep_i(sleep_i), .publish_i(publish_i), .pub_data_i(pub_data_i),
        .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o), .sync_arm_o(sync_arm_o),
        .event_o(event_o), .status_o(status_o), .error_o(error_o),
        .frame_id_o(frame_id_o), .frame_len_o(frame_len_o), .rx_buf_o(rx_buf_o)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] with_par(input logic [5:0] id);
        logic a, b;
        a = id[0] ^ id[1] ^ id[2] ^ id[4];
        b = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
        return {b, a, id};
    endfunction

    function automatic logic [7:0] eac(input logic [7:0] s, input logic [7:0] d);
        int t;
        t = int'(s) + int'(d);
        if (t > 255) t = t - 255;
        return 8'(t);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: compares each expected item in its due cycle
    always @(negedge clk) begin
        if (sb.size() > 0 && sb[0].due == cyc) begin
            exp_t e;
            logic [26:0] a, x;
            e = sb.pop_front();
            a = {status_o, error_o, event_o, tx_valid_o, (e.txv ? tx_data_o : 8'h00), sync_arm_o};
            x = {e.st, e.err, e.ev, e.txv, (e.txv ? e.txb : 8'h00), e.arm};
            chk(a == x, e.tag, {37'd0, a}, {37'd0, x});
        end
    end

    task automatic step(input bit v, input logic [7:0] d, input bit brk, input bit fe,
                        input bit syn, input bit slp, input bit pub,
                        input logic [7:0] est, input logic [6:0] eerr, input bit eev,
                        input bit etxv, input logic [7:0] etxb, input bit earm, input string tag);
        exp_t e;
        rx_valid_i = v; rx_data_i = d; rx_break_i = brk; rx_ferr_i = fe;
        sync_done_i = syn; sleep_i = slp; publish_i = pub;
        e.due = cyc + 1; e.st = est; e.err = eerr; e.ev = eev;
        e.txv = etxv; e.txb = etxb; e.arm = earm; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        rx_valid_i = 0; rx_break_i = 0; rx_ferr_i = 0; sync_done_i = 0; sleep_i = 0; publish_i = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic open_frame(input logic [6:0] err);
        step(1, 8'h00, 1, 0, 0, 0, 0, 8'h01, err, 1, 0, 0, 1, "R2 break");
        step(0, 8'h00, 0, 0, 1, 0, 0, 8'h03, err, 1, 0, 0, 0, "R3 synced");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d [4];
        logic [7:0] s;
        do_reset();
        chk({status_o, error_o, event_o, tx_valid_o, sync_arm_o} == '0, "R1 reset state",
            {status_o, error_o, event_o, tx_valid_o, sync_arm_o}, 0);

        // R5: byte before break; R2: break beats framing error
        step(1, 8'h55, 0, 0, 0, 0, 0, 8'h00, 7'h10, 1, 0, 0, 0, "R5 protocol error");
        step(1, 8'h00, 1, 1, 0, 0, 0, 8'h01, 7'h10, 1, 0, 0, 1, "R2 break priority");
        do_reset();

        // Subscriber frame, length 4
        open_frame(7'h00);
        step(0, 8'h00, 0, 0, 1, 0, 0, 8'h03, 7'h00, 0, 0, 0, 0, "R3 repeat sync ignored");
        step(1, with_par(6'h20), 0, 0, 0, 0, 0, 8'h07, 7'h00, 1, 0, 0, 0, "R6 id accepted");
        chk(frame_id_o == 6'h20, "R6 frame id", frame_id_o, 6'h20);
        chk(frame_len_o == 4'd4, "R6 length 4", frame_len_o, 4);
        d = '{8'hF0, 8'h20, 8'h33, 8'h44};
        s = 8'h00;
        foreach (d[i]) begin
            s = eac(s, d[i]);
            step(1, d[i], 0, 0, 0, 0, 0, (i == 3) ? 8'h2F : 8'h0F, 7'h00, (i == 0 || i == 3), 0, 0, 0,
                 "R7 R12 data byte");
        end
        chk(rx_buf_o[31:0] == 32'hF0203344, "R7 countdown lanes", rx_buf_o, 64'hF0203344);
        step(1, ~s, 0, 0, 0, 0, 0, 8'h67, 7'h00, 1, 0, 0, 0, "R8 checksum good");
        step(1, 8'h12, 0, 0, 0, 0, 0, 8'h00, 7'h08, 1, 0, 0, 0, "R9 byte after complete");
        open_frame(7'h08);
        step(1, with_par(6'h20) ^ 8'h40, 0, 0, 0, 0, 0, 8'h00, 7'h09, 1, 0, 0, 0, "R6 parity error");
        do_reset();

        // Bad checksum, length 2
        open_frame(7'h00);
        step(1, with_par(6'h10), 0, 0, 0, 0, 0, 8'h07, 7'h00, 1, 0, 0, 0, "R6 id 0x10");
        chk(frame_len_o == 4'd2, "R6 length 2", frame_len_o, 2);
        step(1, 8'h80, 0, 0, 0, 0, 0, 8'h0F, 7'h00, 1, 0, 0, 0, "R7 first byte");
        step(1, 8'h90, 0, 0, 0, 0, 0, 8'h2F, 7'h00, 1, 0, 0, 0, "R7 last byte");
        s = eac(eac(8'h00, 8'h80), 8'h90);
        step(1, ~s ^ 8'h01, 0, 0, 0, 0, 0, 8'h00, 7'h04, 1, 0, 0, 0, "R8 checksum error");
        do_reset();

        // Publishing frame
        pub_data_i = 64'h0000_0000_0000_A55A;
        open_frame(7'h00);
        step(1, with_par(6'h00), 0, 0, 0, 0, 1, 8'h17, 7'h00, 1, 1, 8'hA5, 0, "R10 first tx");
        s = eac(eac(8'h00, 8'hA5), 8'h5A);
        step(1, 8'hA5, 0, 0, 0, 0, 0, 8'h17, 7'h00, 0, 1, 8'h5A, 0, "R10 next tx");
        step(1, 8'h5A, 0, 0, 0, 0, 0, 8'h37, 7'h00, 1, 1, ~s, 0, "R10 checksum tx");
        step(1, ~s, 0, 0, 0, 0, 0, 8'h67, 7'h00, 1, 0, 0, 0, "R10 R8 frame done");
        open_frame(7'h00);
        step(1, with_par(6'h00), 0, 0, 0, 0, 1, 8'h17, 7'h00, 1, 1, 8'hA5, 0, "R10 tx again");
        step(1, 8'hA4, 0, 0, 0, 0, 0, 8'h00, 7'h02, 1, 0, 0, 0, "R10 readback mismatch");
        do_reset();

        // UART framing error, then sleep and wake
        step(1, 8'h00, 1, 0, 0, 0, 0, 8'h01, 7'h00, 1, 0, 0, 1, "R2 break");
        step(1, 8'h33, 0, 1, 0, 0, 0, 8'h00, 7'h20, 1, 0, 0, 0, "R4 framing error");
        step(0, 8'h00, 0, 0, 0, 1, 0, 8'h80, 7'h20, 1, 0, 0, 0, "R11 sleep");
        step(1, 8'h55, 0, 0, 0, 0, 0, 8'h80, 7'h20, 0, 0, 0, 0, "R11 other byte ignored");
        step(1, 8'h80, 0, 0, 0, 0, 0, 8'h00, 7'h60, 1, 0, 0, 0, "R11 wake 0x80");
        step(0, 8'h00, 0, 0, 0, 1, 0, 8'h80, 7'h60, 1, 0, 0, 0, "R11 sleep again");
        step(1, 8'h00, 0, 0, 0, 0, 0, 8'h00, 7'h60, 1, 0, 0, 0, "R11 R13 wake 0x00");
        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "R13 all results due", sb.size(), 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule